// File: doc/BRIEF.md
# Floating-Point Normalization Unit

This unit takes one 32-bit floating-point word per cycle and normalizes it. The mantissa is signed, and its implied leading bit is taken to be a copy of the sign bit. Normalization is therefore a signed count: the unit counts the redundant sign bits below the sign, shifts the mantissa left by that count and lowers the exponent by the same amount. In the result the implied bit is dropped again. An exponent of −128 is kept as the code for zero. A zero input, an input that already carries the zero code, and an exponent that would fall too low each lead to a result with that code.

The word layout is exponent in bits 31:24 (two's complement), sign in bit 23 and fraction in bits 22:0. The working mantissa is 25 bits: {sign, sign, fraction}. The result is registered, so it appears one cycle after `in_valid`. The condition flags are registered as well. They change only when the request targets a general register (`dst_is_reg` = 1). The rest of the datapath stays outside: operand fetch, addressing and the carry flag.

Top module: `fpn_norm_unit`

## Requirements
- R1: For a normal case the shift count k is 1 plus the number of leading fraction bits equal to the sign. The result is exponent = input exponent − k, sign bit 23 = sign, and bits 22:0 = bits 22:0 of the mantissa shifted left by k.
- R2: Input exponent −128 (0x80) with sign 0 and fraction 0 gives result 0x80000000 with Z=1 and UF=0.
- R3: Input exponent −128 with a nonzero sign-plus-fraction gives result 0x80000000 with Z=0 and UF=1.
- R4: Any other exponent with sign 0 and fraction 0 gives result 0x80000000 with Z=1 and UF=0.
- R5: If the adjusted exponent is −128 or lower, the result is 0x80000000 with UF=1 and Z=0. An adjusted exponent of exactly −127 is still a normal result.
- R6: When the flags update, N equals the result sign (0 for every zero-code result) and V is 0.
- R7: LUF is set by any flag-updating underflow, whether from R3 or R5. Otherwise it keeps its value, and only reset clears it.
- R8: With `dst_is_reg`=0 the result is still produced, but N, Z, V, UF and LUF keep their values.
- R9: `out_valid` is high exactly one cycle after `in_valid`. `dst_word` keeps its value on cycles without a request.
- R10: After reset, `out_valid`, `dst_word` and all flags are 0.
- R11: The mantissa −1 LSB (sign 1, fraction all ones) is shifted by 24. The result has sign 1, fraction 0 and exponent lowered by 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present on `src_word` |
| src_word | input | 32 | Unnormalized source word |
| dst_is_reg | input | 1 | Request targets a general register; enables flag update |
| out_valid | output | 1 | `dst_word` holds a new result |
| dst_word | output | 32 | Normalized result |
| flag_n | output | 1 | Negative result |
| flag_z | output | 1 | Zero result |
| flag_v | output | 1 | Overflow flag, always cleared on update |
| flag_uf | output | 1 | Underflow of the latest flag-updating request |
| flag_luf | output | 1 | Sticky underflow |

## Verification
The hardest case to reach is the underflow edge. There the exponent lands exactly on −128 after a shift, while one step less gives a valid −127. Uniform random words almost never hit it, because it needs a small exponent and a fraction with exactly the right number of leading sign copies. The stimulus therefore builds words from a chosen shift count and a chosen exponent near the bottom of the range. It adds directed words for both sides of that edge, for the −1 LSB pattern that needs the full 24-position shift, and for the zero code. It also interleaves requests without `dst_is_reg` so that the sticky flag is seen to hold.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

   typedef enum logic [2:0] {
      FPN_NORMAL      = 3'd0,
      FPN_ZERO_IN     = 3'd1,
      FPN_ZCODE_ZERO  = 3'd2,
      FPN_ZCODE_NZ    = 3'd3,
      FPN_UNDERFLOW   = 3'd4
   } fpn_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic uf;
   } fpn_flags_t;

endpackage

// File: rtl/fpn_sign_count.sv
module fpn_sign_count #(
   parameter int MAN_W   = 25,
   parameter int CNT_W   = 5,
   parameter int CHUNK   = 4,
   parameter bit CHUNKED = 1'b1
) (
   input  logic [MAN_W-1:0] man,
   output logic [CNT_W-1:0] count
);
   localparam int D    = MAN_W - 1;
   localparam int NCH  = (D + CHUNK - 1) / CHUNK;
   localparam int PADW = NCH * CHUNK;
   localparam int LZW  = $clog2(CHUNK + 1);

   if (MAN_W < 3)           $error("fpn_sign_count: MAN_W too small");
   if (CHUNK < 1)           $error("fpn_sign_count: CHUNK must be positive");
   if ((1 << CNT_W) <= D)   $error("fpn_sign_count: CNT_W cannot hold the count");

   logic [D-1:0] diff;

   always_comb begin
      for (int i = 0; i < D; i++) begin
         diff[i] = man[i] ^ man[MAN_W-1];
      end
   end

   if (CHUNKED) begin : g_chunked
      logic [PADW-1:0]  padded;
      logic [NCH-1:0]   nz;
      logic [LZW-1:0]   lz [NCH];

      always_comb begin
         padded = '1;
         for (int i = 0; i < D; i++) begin
            padded[i + PADW - D] = diff[i];
         end
      end

      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         logic [CHUNK-1:0] bits;
         assign bits  = padded[PADW-1-c*CHUNK -: CHUNK];
         assign nz[c] = |bits;
         always_comb begin
            lz[c] = LZW'(CHUNK);
            for (int j = 0; j < CHUNK; j++) begin
               if (bits[j]) lz[c] = LZW'(CHUNK - 1 - j);
            end
         end
      end

      always_comb begin
         logic found;
         found = 1'b0;
         count = CNT_W'(D);
         for (int c = 0; c < NCH; c++) begin
            if (!found && nz[c]) begin
               count = CNT_W'(c * CHUNK) + CNT_W'(lz[c]);
               found = 1'b1;
            end
         end
         if (count > CNT_W'(D)) count = CNT_W'(D);
      end
   end else begin : g_linear
      always_comb begin
         count = CNT_W'(D);
         for (int i = 0; i < D; i++) begin
            if (diff[i]) count = CNT_W'(D - 1 - i);
         end
      end
   end

endmodule

// File: rtl/fpn_exp_adjust.sv
module fpn_exp_adjust #(
   parameter int EXP_W = 8,
   parameter int CNT_W = 5
) (
   input  logic [EXP_W-1:0] exp_in,
   input  logic [CNT_W-1:0] shift,
   output logic [EXP_W-1:0] exp_out,
   output logic             below
);
   localparam logic signed [EXP_W:0] FLOOR = {2'b11, {(EXP_W-1){1'b0}}};

   if (CNT_W >= EXP_W) $error("fpn_exp_adjust: shift width must stay below exponent width");

   logic signed [EXP_W:0] ext;
   logic signed [EXP_W:0] amt;
   logic signed [EXP_W:0] res;

   always_comb begin
      ext     = $signed({exp_in[EXP_W-1], exp_in});
      amt     = $signed((EXP_W+1)'(shift));
      res     = ext - amt;
      below   = (res <= FLOOR);
      exp_out = res[EXP_W-1:0];
   end

endmodule

// File: rtl/fpn_classify.sv
module fpn_classify
   import fpn_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W-1:0]  exp_in,
   input  logic              sign,
   input  logic [FRAC_W-1:0] frac,
   input  logic              below,
   output fpn_kind_e         kind
);
   localparam logic [EXP_W-1:0] ZCODE = {1'b1, {(EXP_W-1){1'b0}}};

   logic zcode_in;
   logic man_zero;

   always_comb begin
      zcode_in = (exp_in == ZCODE);
      man_zero = !sign && (frac == '0);
      if (zcode_in)      kind = man_zero ? FPN_ZCODE_ZERO : FPN_ZCODE_NZ;
      else if (man_zero) kind = FPN_ZERO_IN;
      else if (below)    kind = FPN_UNDERFLOW;
      else               kind = FPN_NORMAL;
   end

endmodule

// File: rtl/fpn_norm_unit.sv
module fpn_norm_unit
   import fpn_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int CHUNK   = 4,
   parameter bit CHUNKED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [EXP_W+FRAC_W:0]   src_word,
   input  logic                    dst_is_reg,
   output logic                    out_valid,
   output logic [EXP_W+FRAC_W:0]   dst_word,
   output logic                    flag_n,
   output logic                    flag_z,
   output logic                    flag_v,
   output logic                    flag_uf,
   output logic                    flag_luf
);
   localparam int WORD_W = EXP_W + FRAC_W + 1;
   localparam int MAN_W  = FRAC_W + 2;
   localparam int CNT_W  = $clog2(MAN_W);
   localparam logic [EXP_W-1:0] ZCODE = {1'b1, {(EXP_W-1){1'b0}}};

   if (EXP_W < 3)  $error("fpn_norm_unit: EXP_W too small");
   if (FRAC_W < 2) $error("fpn_norm_unit: FRAC_W too small");

   logic [EXP_W-1:0]  src_exp;
   logic              src_sign;
   logic [FRAC_W-1:0] src_frac;
   logic [MAN_W-1:0]  man;
   logic [MAN_W-1:0]  man_sh;
   logic [CNT_W-1:0]  shift;
   logic [EXP_W-1:0]  exp_adj;
   logic              below;
   fpn_kind_e         kind;
   logic [WORD_W-1:0] result;
   fpn_flags_t        flags_nx;
   fpn_flags_t        flags_q;
   logic              luf_q;

   assign src_exp  = src_word[WORD_W-1 -: EXP_W];
   assign src_sign = src_word[FRAC_W];
   assign src_frac = src_word[FRAC_W-1:0];
   assign man      = {src_sign, src_sign, src_frac};

   fpn_sign_count #(
      .MAN_W   (MAN_W),
      .CNT_W   (CNT_W),
      .CHUNK   (CHUNK),
      .CHUNKED (CHUNKED)
   ) u_count (
      .man   (man),
      .count (shift)
   );

   fpn_exp_adjust #(
      .EXP_W (EXP_W),
      .CNT_W (CNT_W)
   ) u_exp (
      .exp_in  (src_exp),
      .shift   (shift),
      .exp_out (exp_adj),
      .below   (below)
   );

   fpn_classify #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_class (
      .exp_in (src_exp),
      .sign   (src_sign),
      .frac   (src_frac),
      .below  (below),
      .kind   (kind)
   );

   assign man_sh = man << shift;

   always_comb begin
      flags_nx = '0;
      if (kind == FPN_NORMAL) begin
         result     = {exp_adj, man_sh[MAN_W-1], man_sh[FRAC_W-1:0]};
         flags_nx.n = man_sh[MAN_W-1];
      end else begin
         result     = {ZCODE, {(FRAC_W+1){1'b0}}};
      end
      flags_nx.z  = (kind == FPN_ZERO_IN) || (kind == FPN_ZCODE_ZERO);
      flags_nx.uf = (kind == FPN_UNDERFLOW) || (kind == FPN_ZCODE_NZ);
      flags_nx.v  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) dst_word <= result;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         luf_q   <= 1'b0;
      end else if (in_valid && dst_is_reg) begin
         flags_q <= flags_nx;
         luf_q   <= luf_q | flags_nx.uf;
      end
   end

   assign flag_n   = flags_q.n;
   assign flag_z   = flags_q.z;
   assign flag_v   = flags_q.v;
   assign flag_uf  = flags_q.uf;
   assign flag_luf = luf_q;

endmodule

// File: rtl/fpn_norm_chk.sv
module fpn_norm_chk #(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              dst_is_reg,
   input logic              out_valid,
   input logic [WORD_W-1:0] dst_word,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v,
   input logic              flag_uf,
   input logic              flag_luf
);
   localparam logic [WORD_W-1:0] ZWORD = {1'b1, {(WORD_W-1){1'b0}}};

   AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);   // R9
   AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(dst_word)); // R9
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && dst_is_reg) |=> $stable({flag_n, flag_z, flag_v, flag_uf, flag_luf})); // R8
   AST_LUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_luf |=> flag_luf);    // R7
   AST_UF_SETS_LUF: assert property (@(posedge clk) disable iff (!rst_n)
      flag_uf |-> flag_luf);     // R7
   AST_Z_UF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_z && flag_uf));     // R5
   AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_is_reg) |=> !flag_v); // R6
   AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_is_reg) ##1 (flag_z || flag_uf) |-> (dst_word == ZWORD && !flag_n)); // R3
   AST_ZCODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && dst_word[WORD_W-1 -: WORD_W-FRAC_W-1] == ZWORD[WORD_W-1 -: WORD_W-FRAC_W-1])
      |-> dst_word[FRAC_W:0] == '0); // R4

endmodule

bind fpn_norm_unit fpn_norm_chk #(
   .WORD_W (EXP_W + FRAC_W + 1),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .dst_is_reg (dst_is_reg),
   .out_valid  (out_valid),
   .dst_word   (dst_word),
   .flag_n     (flag_n),
   .flag_z     (flag_z),
   .flag_v     (flag_v),
   .flag_uf    (flag_uf),
   .flag_luf   (flag_luf)
);

// File: tb/tb_fpn_norm_unit.sv
module tb_fpn_norm_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_word = '0;
   logic        dst_is_reg = 1'b0;
   logic        out_valid;
   logic [31:0] dst_word;
   logic        flag_n, flag_z, flag_v, flag_uf, flag_luf;

   int n_tests = 0;
   int n_fail  = 0;

   logic e_n = 0, e_z = 0, e_uf = 0, e_luf = 0;

   always #2 clk = ~clk;

   fpn_norm_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .src_word   (src_word),
      .dst_is_reg (dst_is_reg),
      .out_valid  (out_valid),
      .dst_word   (dst_word),
      .flag_n     (flag_n),
      .flag_z     (flag_z),
      .flag_v     (flag_v),
      .flag_uf    (flag_uf),
      .flag_luf   (flag_luf)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void ref_norm(input logic [31:0] w, output logic [31:0] r,
                                    output logic n, output logic z, output logic uf);
      int          e;
      int          k;
      logic [24:0] m;
      e  = int'($signed(w[31:24]));
      r  = 32'h8000_0000;
      n  = 0; z = 0; uf = 0;
      if (e == -128) begin
         z  = (w[23:0] == 24'h0);
         uf = !z;
      end else if (w[23:0] == 24'h0) begin
         z = 1;
      end else begin
         m = {w[23], w[23], w[22:0]};
         k = 0;
         while (k < 24 && m[24] == m[23]) begin
            m = m << 1;
            k++;
         end
         if (e - k <= -128) uf = 1;
         else begin
            r = {8'(e - k), m[24], m[22:0]};
            n = m[24];
         end
      end
   endfunction

   task automatic apply(logic [31:0] w, logic to_reg, string req);
      logic [31:0] r;
      logic        n, z, uf;
      ref_norm(w, r, n, z, uf);
      @(negedge clk);
      src_word   = w;
      dst_is_reg = to_reg;
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid   = 1'b0;
      if (to_reg) begin
         e_n = n; e_z = z; e_uf = uf; e_luf = e_luf | uf;
      end
      check({req, " R9 valid"}, {31'b0, out_valid}, 32'd1);
      check({req, " word"}, dst_word, r);
      check({req, " R6 flags nzv"}, {29'b0, flag_n, flag_z, flag_v}, {29'b0, e_n, e_z, 1'b0});
      check({req, " R8 uf"}, {31'b0, flag_uf}, {31'b0, e_uf});
      check({req, " R7 luf"}, {31'b0, flag_luf}, {31'b0, e_luf});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset", {out_valid, flag_n, flag_z, flag_v, flag_uf, flag_luf, 26'b0}, 32'h0);
      check("R10 reset word", dst_word, 32'h0);
      rst_n = 1'b1;

      apply(32'h8000_0000, 1, "R2 zcode zero");
      apply(32'h8012_3456, 1, "R3 zcode nonzero");
      apply(32'h0500_0000, 1, "R4 zero mantissa");
      apply(32'h0040_0000, 1, "R1 shift 1");
      apply(32'h0A00_0001, 1, "R1 shift 23");
      apply(32'h05C0_0000, 1, "R1 negative");
      apply(32'h03FF_FFFF, 1, "R11 minus one lsb");
      apply(32'h8240_0000, 1, "R1 lands on -127");
      apply(32'h8140_0000, 1, "R5 lands on -128");
      apply(32'h8100_0001, 1, "R5 deep underflow");
      apply(32'h7F7F_FFFF, 1, "R1 max exponent");
      apply(32'h0000_1234, 0, "R8 no flag update");
      apply(32'h8100_0001, 0, "R8 underflow ignored");
      apply(32'h1020_0000, 1, "R7 luf holds");

      // R9 idle: word holds, valid low
      held = dst_word;
      @(negedge clk);
      check("R9 idle valid", {31'b0, out_valid}, 32'd0);
      check("R9 idle word", dst_word, held);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         int          k;
         w = $urandom();
         if (i % 3 == 0) begin
            k = $urandom_range(1, 24);
            w[31:24] = 8'($signed(-128 + $urandom_range(0, 30)));
            w[22:0]  = w[23] ? ~(23'h7FFFFF >> (k - 1)) | (23'h1 << (23 - k))
                             :  (23'h7FFFFF >> (k - 1)) & ~(23'h7FFFFF >> k) | ($urandom() & (23'h7FFFFF >> k));
            if (k == 24) w[22:0] = w[23] ? 23'h7FFFFF : 23'h0;
         end else if (i % 7 == 0) begin
            w[31:24] = 8'h80;
         end
         apply(w, ($urandom() % 4) != 0, "R1 R5 random");
      end

      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset again", {25'b0, out_valid, flag_n, flag_z, flag_v, flag_uf, flag_luf, 1'b0}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule